// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller serving 128 pins. The pins are grouped into four banks of 32. Pin n belongs to bank n/32 and uses bit n%32 of that bank's registers. Each bank holds the following state:

- a direction word;
- an output latch, changed through separate set and clear registers;
- rising-edge and falling-edge detect enables;
- a sticky edge status word;
- two words of alternate-function storage.

A read of a bank's level register gives the latch bit for each output pin and the synchronised pad value for each input pin.

Pad inputs pass through a two-stage synchroniser. Each edge is found by comparing the synchronised value with a registered copy from the previous cycle. Edge status drives three interrupt lines: one for pin 0, one for pin 1, and one for every other pin. While the core is halted, a level change on a selected input pin raises a one-cycle wake request. The register bus is a plain 32-bit interface. Writes take effect on the clock edge, and read data is combinational from the address.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, all direction, latch, enable, status and alternate-function words are zero, pin_oe and pin_out are zero, and all interrupt and wake outputs are low.
- R2: The level, direction, set and clear registers of banks 0..2 sit at base+4*bank, with bases 0x000, 0x00C, 0x018 and 0x024. Bank 3 uses base+0x100. Direction reads back as written, and bit value 1 means output.
- R3: A set-register write ORs the data into the latch. A clear-register write zeroes each latch bit where the data is 1. Reads of set and clear registers return 0.
- R4: A level read returns (latch & dir) | (sync_in & ~dir). sync_in is pin_in delayed by two clock edges.
- R5: pin_oe equals the direction word and pin_out equals latch & dir, for every bank.
- R6: The rising-enable, falling-enable and status registers of banks 0..2 sit at base+4*bank, with bases 0x030, 0x03C and 0x048. Bank 3 uses base+0x100. The enable registers read back as written.
- R7: A status bit is set only for an input pin whose enable for that edge direction is 1, when sync_in differs from the previous sample in that direction. It becomes visible after the third rising clock edge following the pad change.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a new edge and a clear reach the same bit on the same clock edge, the bit ends set.
- R9: irq_pin0 follows status bit 0 of bank 0. irq_pin1 follows status bit 1 of bank 0. irq_other is the OR of all other status bits in all banks.
- R10: wake_req pulses for one cycle, on the third clock edge after the pad change, when core_halted is 1 and a level change is seen on an input pin in the wake mask. The masks for banks 0..3 are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F. Output pins and pins outside the mask never wake.
- R11: Each bank's alternate-function low word sits at 0x054+8*bank and its high word at 0x058+8*bank. Both are plain read/write storage.
- R12: Any offset at or above 0x200, and any unmapped offset below it, reads as 0. Writes to those offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, applied on the clock edge |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_in | input | 128 | Pad input levels |
| pin_out | output | 128 | Driven pad values |
| pin_oe | output | 128 | Pad output enables |
| core_halted | input | 1 | Core is halted, so wake detection is armed |
| irq_pin0 | output | 1 | Interrupt for pin 0 edge status |
| irq_pin1 | output | 1 | Interrupt for pin 1 edge status |
| irq_other | output | 1 | Interrupt for all remaining edge status |
| wake_req | output | 1 | One-cycle wake request |

## Verification
The assertions assume that interrupt lines drop only after a bus write, that wake_req follows a cycle in which core_halted was high, and that bus_wdata is stable across the edge of a direction write. The stimulus respects these conditions. Every write strobe is held for exactly one clock edge, with its address and data set up half a cycle earlier. core_halted and the pad inputs change only at falling edges. Each pad change is followed by enough idle cycles for the synchroniser and edge logic to settle before the next change or read. The single exception is the set-versus-clear collision, where the clear write is deliberately placed on the third edge after the pad change.

// File: rtl/gpio_pkg.sv
// Package: shared constants, register kinds and wake masks for the GPIO controller.
// Assumes four banks of 32 pins; the address map is fixed to that shape.
package gpio_pkg;

    localparam int NUM_BANKS = 4;
    localparam int BANK_W    = 32;
    localparam int PIN_W     = NUM_BANKS * BANK_W;
    localparam int BANK_IW   = $clog2(NUM_BANKS);

    typedef enum logic [3:0] {
        K_NONE, K_LEVEL, K_DIR, K_SET, K_CLR,
        K_RISE, K_FALL, K_STAT, K_AFLO, K_AFHI
    } reg_kind_e;

    // Kind of the n-th 12-byte group in the low part of the map.
    function automatic reg_kind_e group_kind(input int n);
        case (n)
            0:       return K_LEVEL;
            1:       return K_DIR;
            2:       return K_SET;
            3:       return K_CLR;
            4:       return K_RISE;
            5:       return K_FALL;
            6:       return K_STAT;
            default: return K_NONE;
        endcase
    endfunction

    // Fixed per-bank set of pins that may wake a halted core.
    function automatic logic [BANK_W-1:0] wake_mask(input int b);
        case (b)
            0:       return 32'h8003_FE1B;
            1:       return 32'h0020_01FC;
            2:       return 32'hEC08_0000;
            3:       return 32'h0012_007F;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync.sv
// Module: multi-stage synchroniser for the pad input vector.
// Assumes pads are asynchronous; output lags input by STAGES clock edges.
module gpio_sync #(
    parameter int W      = 128,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    // Shift the pad vector through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_addr_decode.sv
// Module: maps a byte offset to a register kind and bank index.
// Assumes word-aligned accesses; anything else, or offsets >= 0x200, decode to K_NONE.
module gpio_addr_decode
    import gpio_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]  addr,
    output reg_kind_e          kind,
    output logic [BANK_IW-1:0] bank
);

    localparam int GROUPS   = 7;
    localparam int AF_FIRST = 21;

    logic       in_window;
    logic [5:0] word;

    assign in_window = (addr[ADDR_W-1:9] == '0) && (addr[1:0] == 2'b00);
    assign word      = addr[7:2];

    // Search the group table; low page holds banks 0..2, upper page holds bank 3.
    always_comb begin
        kind = K_NONE;
        bank = '0;
        if (in_window) begin
            for (int k = 0; k < GROUPS; k++) begin
                if (!addr[8]) begin
                    for (int b = 0; b < NUM_BANKS - 1; b++) begin
                        if (word == 6'(3 * k + b)) begin
                            kind = group_kind(k);
                            bank = BANK_IW'(b);
                        end
                    end
                end else if (word == 6'(3 * k)) begin
                    kind = group_kind(k);
                    bank = BANK_IW'(NUM_BANKS - 1);
                end
            end
            if (!addr[8]) begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (word == 6'(AF_FIRST + 2 * b)) begin
                        kind = K_AFLO;
                        bank = BANK_IW'(b);
                    end
                    if (word == 6'(AF_FIRST + 2 * b + 1)) begin
                        kind = K_AFHI;
                        bank = BANK_IW'(b);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/gpio_bank.sv
// Module: register state, edge detection and wake sensing for one 32-pin bank.
// Assumes pin_sync is already synchronised; a new edge wins over a same-cycle clear.
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int          W    = 32,
    parameter logic [W-1:0] WAKE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  reg_kind_e    kind,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] rd_data,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] stat,
    output logic         wake_hit
);

    logic [W-1:0] dir_q, latch_q, rise_q, fall_q, stat_q, aflo_q, afhi_q, prev_q;
    logic [W-1:0] rise_hit, fall_hit, clr_mask;

    assign rise_hit = pin_sync & ~prev_q & ~dir_q & rise_q;
    assign fall_hit = ~pin_sync & prev_q & ~dir_q & fall_q;
    assign clr_mask = (wr_en && kind == K_STAT) ? wdata : '0;

    // Configuration and output latch updates from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '0;
            latch_q <= '0;
            rise_q  <= '0;
            fall_q  <= '0;
            aflo_q  <= '0;
            afhi_q  <= '0;
        end else if (wr_en) begin
            case (kind)
                K_DIR:   dir_q   <= wdata;
                K_SET:   latch_q <= latch_q | wdata;
                K_CLR:   latch_q <= latch_q & ~wdata;
                K_RISE:  rise_q  <= wdata;
                K_FALL:  fall_q  <= wdata;
                K_AFLO:  aflo_q  <= wdata;
                K_AFHI:  afhi_q  <= wdata;
                default: ;
            endcase
        end
    end

    // Sticky edge status with write-one-to-clear; new edges take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            prev_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_mask) | rise_hit | fall_hit;
            prev_q <= pin_sync;
        end
    end

    // Read data for the selected register kind.
    always_comb begin
        case (kind)
            K_LEVEL: rd_data = (latch_q & dir_q) | (pin_sync & ~dir_q);
            K_DIR:   rd_data = dir_q;
            K_RISE:  rd_data = rise_q;
            K_FALL:  rd_data = fall_q;
            K_STAT:  rd_data = stat_q;
            K_AFLO:  rd_data = aflo_q;
            K_AFHI:  rd_data = afhi_q;
            default: rd_data = '0;
        endcase
    end

    assign pin_out  = latch_q & dir_q;
    assign pin_oe   = dir_q;
    assign stat     = stat_q;
    assign wake_hit = |((pin_sync ^ prev_q) & ~dir_q & WAKE);

endmodule

// File: rtl/gpio_bank_ctrl.sv
// Module: top of the banked GPIO controller; decodes the bus, holds four banks,
// merges interrupts and registers the wake request.
// Assumes one access per cycle; reads are combinational, writes land on the clock edge.
module gpio_bank_ctrl
    import gpio_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe,
    input  logic              core_halted,
    output logic              irq_pin0,
    output logic              irq_pin1,
    output logic              irq_other,
    output logic              wake_req
);

    reg_kind_e          kind;
    logic [BANK_IW-1:0] bank_sel;
    logic [PIN_W-1:0]   pin_sync;
    logic [BANK_W-1:0]  bank_rd   [NUM_BANKS];
    logic [BANK_W-1:0]  bank_stat [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_wake;

    gpio_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    gpio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .kind (kind),
        .bank (bank_sel)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_bank #(.W(BANK_W), .WAKE(wake_mask(b))) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bus_wr_en && kind != K_NONE && bank_sel == BANK_IW'(b)),
            .kind     (kind),
            .wdata    (bus_wdata),
            .pin_sync (pin_sync[b*BANK_W +: BANK_W]),
            .rd_data  (bank_rd[b]),
            .pin_out  (pin_out[b*BANK_W +: BANK_W]),
            .pin_oe   (pin_oe[b*BANK_W +: BANK_W]),
            .stat     (bank_stat[b]),
            .wake_hit (bank_wake[b])
        );
    end

    assign bus_rdata = (kind == K_NONE) ? '0 : bank_rd[bank_sel];

    // Split interrupts: dedicated lines for pins 0 and 1, one shared line for the rest.
    always_comb begin
        irq_pin0  = bank_stat[0][0];
        irq_pin1  = bank_stat[0][1];
        irq_other = |bank_stat[0][BANK_W-1:2];
        for (int b = 1; b < NUM_BANKS; b++) irq_other = irq_other | (|bank_stat[b]);
    end

    // Register the wake request while the core is halted.
    always_ff @(posedge clk) begin
        if (!rst_n) wake_req <= 1'b0;
        else        wake_req <= core_halted && (|bank_wake);
    end

endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
// Module: property checker for gpio_bank_ctrl, attached with bind.
// Assumes write strobes last one clock edge and bus data is stable across that edge.
module gpio_bank_ctrl_chk #(
    parameter int ADDR_W = 12,
    parameter int PIN_W  = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [PIN_W-1:0]  pin_out,
    input logic [PIN_W-1:0]  pin_oe,
    input logic              core_halted,
    input logic              irq_pin0,
    input logic              irq_pin1,
    input logic              irq_other,
    input logic              wake_req
);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0 && !irq_pin0 && !irq_pin1 && !irq_other && !wake_req));

    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == ADDR_W'('h00C)) |=> (pin_oe[31:0] == $past(bus_wdata)));

    p_drive_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);

    p_irq0_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_pin0) |-> $past(bus_wr_en));

    p_irq1_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_pin1) |-> $past(bus_wr_en));

    p_irqx_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_other) |-> $past(bus_wr_en));

    p_wake_halted_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(core_halted));

    p_high_write_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr[ADDR_W-1:9] != '0) |=> ($stable(pin_oe) && $stable(pin_out)));

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.ADDR_W(ADDR_W), .PIN_W(gpio_pkg::PIN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr_en   (bus_wr_en),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .core_halted (core_halted),
    .irq_pin0    (irq_pin0),
    .irq_pin1    (irq_pin1),
    .irq_other   (irq_other),
    .wake_req    (wake_req)
);

// File: tb/tb_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_bank_ctrl;

    localparam int AW = 12;
    localparam int PW = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr_en = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [PW-1:0] pin_in = '0;
    logic [PW-1:0] pin_out, pin_oe;
    logic          core_halted = 1'b0;
    logic          irq_pin0, irq_pin1, irq_other, wake_req;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    gpio_bank_ctrl #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .core_halted(core_halted),
        .irq_pin0(irq_pin0), .irq_pin1(irq_pin1), .irq_other(irq_other),
        .wake_req(wake_req)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 12'h00C, 32'hFFFF_0000, 4'd2},   // R2 dir bank0
        '{1'b0, 12'h00C, 32'hFFFF_0000, 4'd2},   // R2
        '{1'b1, 12'h018, 32'h1234_5678, 4'd3},   // R3 set bank0
        '{1'b0, 12'h018, 32'h0000_0000, 4'd3},   // R3 set reads zero
        '{1'b1, 12'h024, 32'h0000_0078, 4'd3},   // R3 clear
        '{1'b0, 12'h000, 32'h1234_0000, 4'd4},   // R4 level mixes latch and input
        '{1'b1, 12'h10C, 32'h0000_FFFF, 4'd2},   // R2 bank3 dir
        '{1'b0, 12'h10C, 32'h0000_FFFF, 4'd2},   // R2
        '{1'b0, 12'h010, 32'h0000_0000, 4'd2},   // R2 bank1 dir untouched
        '{1'b1, 12'h118, 32'hA5A5_A5A5, 4'd3},   // R3 set bank3
        '{1'b0, 12'h124, 32'h0000_0000, 4'd3},   // R3 clear reads zero
        '{1'b0, 12'h100, 32'h0000_A5A5, 4'd4},   // R4 bank3 level
        '{1'b1, 12'h034, 32'hDEAD_BEEF, 4'd6},   // R6 rise bank1
        '{1'b0, 12'h034, 32'hDEAD_BEEF, 4'd6},   // R6
        '{1'b1, 12'h13C, 32'hCAFE_F00D, 4'd6},   // R6 fall bank3
        '{1'b0, 12'h13C, 32'hCAFE_F00D, 4'd6},   // R6
        '{1'b1, 12'h06C, 32'h1111_2222, 4'd11},  // R11 af low bank3
        '{1'b1, 12'h070, 32'h3333_4444, 4'd11},  // R11 af high bank3
        '{1'b0, 12'h06C, 32'h1111_2222, 4'd11},  // R11
        '{1'b0, 12'h070, 32'h3333_4444, 4'd11},  // R11
        '{1'b0, 12'h058, 32'h0000_0000, 4'd11},  // R11 other af word untouched
        '{1'b1, 12'h20C, 32'hFFFF_FFFF, 4'd12},  // R12 alias of dir above window
        '{1'b0, 12'h00C, 32'hFFFF_0000, 4'd12},  // R12 dir unchanged
        '{1'b1, 12'h0F0, 32'hFFFF_FFFF, 4'd12},  // R12 unmapped low offset
        '{1'b0, 12'h0F0, 32'h0000_0000, 4'd12}   // R12 reads zero
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_wr_en = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic read_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
        bus_addr = a;
        #1;
        check(bus_rdata, exp, req);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Toggle one pad and count wake pulses over the following cycles.
    task automatic wake_probe(input int pin, input int exp_cnt, input string req);
        int cnt = 0;
        pin_in[pin] = ~pin_in[pin];
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (wake_req) cnt++;
        end
        check(32'(cnt), 32'(exp_cnt), req);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        // R1 reset state observed while reset is held
        check(pin_oe[31:0], 32'h0, "R1");
        check(32'({irq_pin0, irq_pin1, irq_other, wake_req}), 32'h0, "R1");
        rst_n = 1'b1;
        idle(1);
        read_chk(12'h048, 32'h0, "R1");
        read_chk(12'h054, 32'h0, "R1");

        for (int i = 0; i < NV; i++) begin
            if (TBL[i].wr) bus_write(TBL[i].addr, TBL[i].data);
            else read_chk(TBL[i].addr, TBL[i].data, $sformatf("R%0d", TBL[i].req));
        end

        // R5 driven values
        check(pin_oe[31:0], 32'hFFFF_0000, "R5");
        check(pin_out[31:0], 32'h1234_0000, "R5");
        check(pin_out[127:96], 32'h0000_A5A5, "R5");
        check(pin_oe[127:96], 32'h0000_FFFF, "R5");

        // R7 edges: pins 0,2,16 rising, pin 1 falling; pin 16 is an output
        bus_write(12'h030, 32'h0001_0005);
        bus_write(12'h03C, 32'h0000_0002);
        pin_in[0] = 1'b1; pin_in[16] = 1'b1;
        idle(2);
        read_chk(12'h048, 32'h0, "R7 not yet");
        idle(1);
        read_chk(12'h048, 32'h1, "R7");
        read_chk(12'h000, 32'h1234_0001, "R4");
        check(32'({irq_pin0, irq_pin1, irq_other}), 32'b100, "R9");
        pin_in[1] = 1'b1; idle(4);
        read_chk(12'h048, 32'h1, "R7 rise not enabled");
        pin_in[1] = 1'b0; idle(4);
        read_chk(12'h048, 32'h3, "R7 fall");
        check(32'(irq_pin1), 32'h1, "R9");
        pin_in[2] = 1'b1; idle(4);
        read_chk(12'h048, 32'h7, "R7");
        check(32'(irq_other), 32'h1, "R9");
        bus_write(12'h048, 32'h2);
        read_chk(12'h048, 32'h5, "R8");
        check(32'({irq_pin0, irq_pin1}), 32'b10, "R8");
        bus_write(12'h048, 32'h5);
        read_chk(12'h048, 32'h0, "R8");
        check(32'(irq_other), 32'h0, "R9");
        pin_in[2] = 1'b0; idle(4);
        read_chk(12'h048, 32'h0, "R7 fall not enabled");

        // R8 new edge wins over a same-edge clear
        pin_in[0] = 1'b0; idle(4);
        pin_in[0] = 1'b1; idle(2);
        bus_write(12'h048, 32'h1);
        read_chk(12'h048, 32'h1, "R8 set beats clear");
        bus_write(12'h048, 32'h1);

        // R9 other bank feeds the shared line
        pin_in[41] = 1'b1; idle(4);
        read_chk(12'h04C, 32'h0000_0200, "R7 bank1");
        check(32'({irq_pin0, irq_pin1, irq_other}), 32'b001, "R9");
        bus_write(12'h04C, 32'h0000_0200);
        check(32'(irq_other), 32'h0, "R9");

        // R10 wake behaviour
        core_halted = 1'b1;
        idle(2);
        pin_in[3] = 1'b1;
        idle(2);
        check(32'(wake_req), 32'h0, "R10 early");
        idle(1);
        check(32'(wake_req), 32'h1, "R10");
        idle(1);
        check(32'(wake_req), 32'h0, "R10 pulse");
        wake_probe(2, 0, "R10 unmasked pin");
        wake_probe(31, 0, "R10 output pin");
        wake_probe(83, 1, "R10 bank2");
        core_halted = 1'b0;
        wake_probe(3, 0, "R10 not halted");

        // R1 reset in mid-run
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        read_chk(12'h00C, 32'h0, "R1");
        read_chk(12'h06C, 32'h0, "R1");
        read_chk(12'h034, 32'h0, "R1");
        check(pin_oe[127:96], 32'h0, "R1");
        check(pin_out[127:96], 32'h0, "R1");

        finish_run();
    end

endmodule